// File: doc/BRIEF.md
# Block-Length SPI Master with Word FIFO

This block is an SPI master that moves a programmed number of bytes between a register bus and one of several serial devices. Software programs a byte count, fills or drains an eight-word FIFO through a single 32-bit data register, and writes a control word that carries the clock divisor, the target device, the data width and the direction. Setting the start bit in that word launches the transfer. The block shifts whole bytes, either on one data line or on four, and packs them into 32-bit words with the least significant byte first.

The chip select of the chosen device goes active at the start and stays active after the last byte. Software can then issue more transfers inside the same framed sequence, and it ends the frame by writing 0 to the select register. The engine stalls with the serial clock parked low whenever the FIFO cannot supply or accept the next word. A one-cycle transfer-finished pulse is exported to the interrupt logic.

Top module: `spiBlockMaster`

## Requirements
- R1: After reset every readable register returns 0, all chip selects are high (inactive), the serial clock is low and the finished pulse is low.
- R2: Registers are at word addresses 0 (control), 1 (select), 2 (length), 3 (data) and 4 (status). The control fields are the divisor in bits 2:0, the device in bits 7:6, quad mode in bit 12 (1 = four lines), the direction in bit 13 (1 = write to the device, 0 = read) and start/busy in bit 15. They read back as written. Writes to control and length are ignored while busy.
- R3: The serial clock idles low and runs at 2^(divisor+1) system cycles per period. The device sees data that changes after a falling edge, and the master samples input at the rising edge.
- R4: In single-line mode each byte is sent most significant bit first on data line 0, and input is sampled from data line 1.
- R5: In quad mode all four lines carry the high nibble first, then the low nibble. Line 3 is the nibble MSB. The lines are driven only in the write direction.
- R6: Bytes map onto 32-bit words least significant byte first. On a write, the unused bytes of the final word are discarded. On a read, a final partial word is padded with zero bytes.
- R7: The chip select of the programmed device (output bit = device number) goes low when the transfer starts. It stays low after completion until software writes 0 to bit 0 of the select register while idle. A write of 0 while busy is ignored. Select bit 0 reads 1 while the device is selected. At most one chip select is ever low, and device 3 selects none.
- R8: The length register holds a 21-bit byte count (bits 20:0, upper bits ignored). A count of zero completes without any serial clock edge.
- R9: The FIFO holds 8 words, and status bit 0 reads 1 while it is full. A data write to a full FIFO is dropped. A data read from an empty FIFO returns 0.
- R10: In read direction, the engine waits before starting a word while the FIFO is full. In write direction, it waits before a word while the FIFO is empty. The serial clock stays low during the wait.
- R11: When the last byte completes, busy clears and the finished output pulses high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register word address |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (pops the FIFO at the data address) |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational from address |
| spiClk | output | 1 | Serial clock |
| spiCsN | output | NUM_CS | Active-low chip selects |
| spiDataOut | output | 4 | Serial data driven to the device |
| spiDataOe | output | 4 | Output enable per data line |
| spiDataIn | input | 4 | Serial data from the device |
| xferDone | output | 1 | One-cycle transfer-finished pulse |

## Verification
A corrupted byte counter shows up as a finished pulse after the wrong number of serial clock periods, or as a missing pulse. A wrong byte index inside a word shows up as swapped or duplicated bytes on the data line within one byte time. A chip-select flag that drops early or never drops is visible on the select pins in the same cycle, because the bench compares them against its own model on every clock. A FIFO that misreports full either lets the serial clock run past the 32nd byte of a read or parks it early, and the bench checks this with an exact count of rising edges.

// File: rtl/spiPkg.sv
package spiPkg;

  localparam int WORD_W = 32;
  localparam int DEV_W  = 2;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_SEL  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LEN  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd4;

  localparam int BIT_DEV_LO = 6;
  localparam int BIT_QUAD   = 12;
  localparam int BIT_DIR    = 13;
  localparam int BIT_START  = 15;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_STORE,
    ST_FINISH
  } engState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       active;
    logic       dirWrite;
    logic       quad;
    logic       loadByte;
    logic       sampleIn;
    logic       shiftNext;
    logic       storeByte;
    logic       pushWord;
    logic [1:0] byteIdx;
    logic       swPush;
    logic       swPop;
  } dpStrobe_t;

endpackage

// File: rtl/spiFifo.sv
module spiFifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [PTR_W:0]   count;
  logic             pushOk, popOk;

  assign empty  = (count == '0);
  assign full   = (count == (PTR_W+1)'(DEPTH));
  assign pushOk = push && !full;
  assign popOk  = pop && !empty;
  assign head   = empty ? '0 : mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= wrPtr + 1'b1;
      if (popOk)  rdPtr <= rdPtr + 1'b1;
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

endmodule

// File: rtl/spiCtrl.sv
module spiCtrl
  import spiPkg::*;
#(
  parameter int DIV_W  = 3,
  parameter int LEN_W  = 21,
  parameter int NUM_CS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [WORD_W-1:0] busWrData,
  input  logic              fifoEmpty,
  input  logic              fifoFull,
  output logic [WORD_W-1:0] ctrlRdData,
  output dpStrobe_t         strobe,
  output logic              spiClk,
  output logic [NUM_CS-1:0] spiCsN,
  output logic              busy,
  output logic              csActive,
  output logic              xferDone
);

  localparam int HALF_W = 1 << DIV_W;

  logic [DIV_W-1:0]  cfgDiv;
  logic [DEV_W-1:0]  cfgDev;
  logic              cfgQuad, cfgDir;
  logic [LEN_W-1:0]  lenReg, bytesLeft;
  engState_e         state;
  logic [1:0]        byteIdx;
  logic [2:0]        unitCnt;
  logic [HALF_W-1:0] divCnt, halfLimit;
  logic              spiClkQ;

  logic wrCtrl, wrSel, wrLen, startReq, tick, unitLast, canLoad, lastByte;
  logic unusedWr;

  assign unusedWr  = ^busWrData[WORD_W-1:LEN_W];
  assign wrCtrl    = busWrEn && (busAddr == ADDR_CTRL);
  assign wrSel     = busWrEn && (busAddr == ADDR_SEL);
  assign wrLen     = busWrEn && (busAddr == ADDR_LEN);
  assign startReq  = wrCtrl && busWrData[BIT_START] && !busy;
  assign halfLimit = HALF_W'(1) << cfgDiv;
  assign tick      = (divCnt == halfLimit - 1'b1);
  assign unitLast  = (unitCnt == (cfgQuad ? 3'd1 : 3'd7));
  assign lastByte  = (bytesLeft == LEN_W'(1));
  // A new word needs FIFO data (write) or FIFO room (read)
  assign canLoad   = (byteIdx != 2'd0) || (cfgDir ? !fifoEmpty : !fifoFull);

  // Configuration and length, frozen while busy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgDiv  <= '0;
      cfgDev  <= '0;
      cfgQuad <= 1'b0;
      cfgDir  <= 1'b0;
      lenReg  <= '0;
    end else if (!busy) begin
      if (wrCtrl) begin
        cfgDiv  <= busWrData[DIV_W-1:0];
        cfgDev  <= busWrData[BIT_DEV_LO +: DEV_W];
        cfgQuad <= busWrData[BIT_QUAD];
        cfgDir  <= busWrData[BIT_DIR];
      end
      if (wrLen) lenReg <= busWrData[LEN_W-1:0];
    end
  end

  // Chip-select frame flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                     csActive <= 1'b0;
    else if (startReq)                             csActive <= 1'b1;
    else if (wrSel && !busy && !busWrData[0])      csActive <= 1'b0;
  end

  // Byte engine
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      xferDone  <= 1'b0;
      bytesLeft <= '0;
      byteIdx   <= '0;
      unitCnt   <= '0;
      divCnt    <= '0;
      spiClkQ   <= 1'b0;
    end else begin
      xferDone <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            busy      <= 1'b1;
            bytesLeft <= lenReg;
            byteIdx   <= '0;
            state     <= (lenReg == '0) ? ST_FINISH : ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (canLoad) begin
            divCnt  <= '0;
            unitCnt <= '0;
            spiClkQ <= 1'b0;
            state   <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            divCnt <= '0;
            if (!spiClkQ) begin
              spiClkQ <= 1'b1;
            end else begin
              spiClkQ <= 1'b0;
              unitCnt <= unitCnt + 1'b1;
              if (unitLast) state <= ST_STORE;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_STORE: begin
          bytesLeft <= bytesLeft - 1'b1;
          byteIdx   <= byteIdx + 1'b1;
          state     <= lastByte ? ST_FINISH : ST_LOAD;
        end
        ST_FINISH: begin
          busy     <= 1'b0;
          xferDone <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign spiClk = spiClkQ;

  // Strobes to the datapath
  always_comb begin
    strobe           = '0;
    strobe.active    = busy;
    strobe.dirWrite  = cfgDir;
    strobe.quad      = cfgQuad;
    strobe.byteIdx   = byteIdx;
    strobe.loadByte  = (state == ST_LOAD) && canLoad;
    strobe.sampleIn  = (state == ST_SHIFT) && tick && !spiClkQ;
    strobe.shiftNext = (state == ST_SHIFT) && tick && spiClkQ;
    strobe.storeByte = (state == ST_STORE) && !cfgDir;
    strobe.pushWord  = (state == ST_STORE) && !cfgDir &&
                       ((byteIdx == 2'd3) || lastByte);
    strobe.swPush    = busWrEn && (busAddr == ADDR_DATA) && !(busy && !cfgDir);
    strobe.swPop     = busRdEn && (busAddr == ADDR_DATA);
  end

  // One chip-select line per device number
  for (genvar i = 0; i < NUM_CS; i++) begin : gCs
    assign spiCsN[i] = !(csActive && (cfgDev == DEV_W'(i)));
  end

  // Register readback (data address handled in the top)
  always_comb begin
    ctrlRdData = '0;
    case (busAddr)
      ADDR_CTRL: begin
        ctrlRdData[DIV_W-1:0]            = cfgDiv;
        ctrlRdData[BIT_DEV_LO +: DEV_W]  = cfgDev;
        ctrlRdData[BIT_QUAD]             = cfgQuad;
        ctrlRdData[BIT_DIR]              = cfgDir;
        ctrlRdData[BIT_START]            = busy;
      end
      ADDR_SEL:  ctrlRdData[0]          = csActive;
      ADDR_LEN:  ctrlRdData[LEN_W-1:0]  = lenReg;
      ADDR_STAT: ctrlRdData[0]          = fifoFull;
      default:   ctrlRdData             = '0;
    endcase
  end

endmodule

// File: rtl/spiDatapath.sv
module spiDatapath
  import spiPkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] busWrData,
  input  logic [3:0]        spiDataIn,
  output logic [WORD_W-1:0] fifoHead,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic [3:0]        spiDataOut,
  output logic [3:0]        spiDataOe
);

  logic [7:0]        shiftOut, shiftIn;
  logic [23:0]       txRest;
  logic [WORD_W-1:0] rxWord, rxMerged;
  logic              fifoPush, fifoPop, engPop;
  logic [WORD_W-1:0] fifoPushData;

  assign engPop       = strobe.loadByte && strobe.dirWrite && (strobe.byteIdx == 2'd0);
  assign fifoPop      = engPop || strobe.swPop;
  assign fifoPush     = strobe.pushWord || strobe.swPush;
  assign rxMerged     = rxWord | (WORD_W'(shiftIn) << {strobe.byteIdx, 3'b000});
  assign fifoPushData = strobe.pushWord ? rxMerged : busWrData;

  spiFifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) uFifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (fifoPush),
    .pushData (fifoPushData),
    .pop      (fifoPop),
    .head     (fifoHead),
    .empty    (fifoEmpty),
    .full     (fifoFull)
  );

  // Transmit byte and remainder of the current word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftOut <= '0;
      txRest   <= '0;
    end else if (strobe.loadByte) begin
      if (!strobe.dirWrite) begin
        shiftOut <= '0;
      end else if (engPop) begin
        shiftOut <= fifoHead[7:0];
        txRest   <= fifoHead[31:8];
      end else begin
        shiftOut <= txRest[7:0];
        txRest   <= {8'h00, txRest[23:8]};
      end
    end else if (strobe.shiftNext) begin
      shiftOut <= strobe.quad ? {shiftOut[3:0], 4'h0} : {shiftOut[6:0], 1'b0};
    end
  end

  // Receive byte and word assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftIn <= '0;
      rxWord  <= '0;
    end else begin
      if (strobe.sampleIn)
        shiftIn <= strobe.quad ? {shiftIn[3:0], spiDataIn} : {shiftIn[6:0], spiDataIn[1]};
      if (strobe.storeByte)
        rxWord <= strobe.pushWord ? '0 : rxMerged;
    end
  end

  assign spiDataOut = strobe.quad ? shiftOut[7:4] : {3'b000, shiftOut[7]};

  always_comb begin
    if (!strobe.active)   spiDataOe = 4'h0;
    else if (strobe.quad) spiDataOe = strobe.dirWrite ? 4'hF : 4'h0;
    else                  spiDataOe = 4'h1;
  end

endmodule

// File: rtl/spiBlockMaster.sv
module spiBlockMaster
  import spiPkg::*;
#(
  parameter int DIV_W      = 3,
  parameter int LEN_W      = 21,
  parameter int NUM_CS     = 3,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              spiClk,
  output logic [NUM_CS-1:0] spiCsN,
  output logic [3:0]        spiDataOut,
  output logic [3:0]        spiDataOe,
  input  logic [3:0]        spiDataIn,
  output logic              xferDone
);

  dpStrobe_t         strobe;
  logic [WORD_W-1:0] ctrlRdData, fifoHead;
  logic              fifoEmpty, fifoFull, busy, csActive;

  spiCtrl #(.DIV_W(DIV_W), .LEN_W(LEN_W), .NUM_CS(NUM_CS)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .busWrData  (busWrData),
    .fifoEmpty  (fifoEmpty),
    .fifoFull   (fifoFull),
    .ctrlRdData (ctrlRdData),
    .strobe     (strobe),
    .spiClk     (spiClk),
    .spiCsN     (spiCsN),
    .busy       (busy),
    .csActive   (csActive),
    .xferDone   (xferDone)
  );

  spiDatapath #(.FIFO_DEPTH(FIFO_DEPTH)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busWrData  (busWrData),
    .spiDataIn  (spiDataIn),
    .fifoHead   (fifoHead),
    .fifoEmpty  (fifoEmpty),
    .fifoFull   (fifoFull),
    .spiDataOut (spiDataOut),
    .spiDataOe  (spiDataOe)
  );

  assign busRdData = (busAddr == ADDR_DATA) ? fifoHead : ctrlRdData;

endmodule

// File: rtl/spiBlockMasterChk.sv
module spiBlockMasterChk #(
  parameter int NUM_CS = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              spiClk,
  input logic [NUM_CS-1:0] spiCsN,
  input logic              xferDone,
  input logic              busy,
  input logic              csActive,
  input logic              busWrEn,
  input logic [2:0]        busAddr,
  input logic              busWrBit0
);

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~spiCsN) <= 1); // R7

  AST_CLK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !spiClk); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> !busy); // R11

  AST_START_SELECTS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> csActive); // R7

  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (csActive && !(busWrEn && busAddr == 3'd1 && !busWrBit0)) |=> csActive); // R7

endmodule

bind spiBlockMaster spiBlockMasterChk #(.NUM_CS(NUM_CS)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .spiClk    (spiClk),
  .spiCsN    (spiCsN),
  .xferDone  (xferDone),
  .busy      (busy),
  .csActive  (csActive),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busWrBit0 (busWrData[0])
);

// File: tb/tb_spiBlockMaster.sv
module tb_spiBlockMaster;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [31:0] busWrData = '0, busRdData;
  logic        spiClk, xferDone;
  logic [2:0]  spiCsN;
  logic [3:0]  spiDataOut, spiDataOe, spiDataIn;

  spiBlockMaster dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;

  // Reference model state
  bit       modelBusy = 0, modelSel = 0, quadMode = 0;
  int       modelDev = 0;
  int       doneCount = 0;
  logic [7:0] slaveTx[$];
  logic [7:0] slaveCur = '0;
  int       slaveUnit = 0;
  logic [7:0] mosiSeen[$];
  logic [7:0] mosiAcc = '0;
  int       mosiUnit = 0;
  int       riseCount = 0;
  realtime  riseT1 = 0, riseT2 = 0;

  assign spiDataIn = quadMode ? slaveCur[7:4] : {2'b00, slaveCur[7], 1'b0};

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Device model: advances output after each falling serial edge
  initial forever begin
    @(negedge spiClk);
    slaveUnit++;
    slaveCur = quadMode ? {slaveCur[3:0], 4'h0} : {slaveCur[6:0], 1'b0};
    if (slaveUnit == (quadMode ? 2 : 8)) begin
      slaveUnit = 0;
      slaveCur  = (slaveTx.size() > 0) ? slaveTx.pop_front() : 8'h00;
    end
  end

  // Device model: captures master output at each rising serial edge
  initial forever begin
    @(posedge spiClk);
    riseCount++;
    if (riseCount == 1) riseT1 = $realtime;
    if (riseCount == 2) riseT2 = $realtime;
    mosiAcc = quadMode ? {mosiAcc[3:0], spiDataOut} : {mosiAcc[6:0], spiDataOut[0]};
    mosiUnit++;
    if (mosiUnit == (quadMode ? 2 : 8)) begin
      mosiUnit = 0;
      mosiSeen.push_back(mosiAcc);
    end
  end

  // Per-clock comparison of chip selects against the model
  initial forever begin
    @(posedge clk);
    #2;
    if (rstN) begin
      logic [2:0] expCs;
      expCs = 3'b111;
      if (modelSel && modelDev < 3) expCs[modelDev] = 1'b0;
      check(spiCsN == expCs, "R7", "chip selects", 32'(spiCsN), 32'(expCs));
      if (xferDone) begin
        doneCount++;
        modelBusy = 0;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  task automatic wrReg(logic [2:0] addr, logic [31:0] data);
    @(negedge clk);
    busAddr = addr; busWrData = data; busWrEn = 1'b1;
    @(posedge clk);
    if (addr == 3'd0 && data[15] && !modelBusy) begin
      modelBusy = 1; modelSel = 1; modelDev = int'(data[7:6]);
    end
    if (addr == 3'd1 && !data[0] && !modelBusy) modelSel = 0;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [2:0] addr, output logic [31:0] data);
    @(negedge clk);
    busAddr = addr; busRdEn = 1'b1;
    #1 data = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic startXfer(int div, int dev, bit quad, bit dirWr, int len, logic [7:0] devBytes[$]);
    wrReg(3'd2, 32'(len));
    quadMode  = quad;
    slaveTx   = devBytes;
    slaveCur  = (slaveTx.size() > 0) ? slaveTx.pop_front() : 8'h00;
    slaveUnit = 0;
    mosiSeen.delete();
    mosiUnit  = 0;
    riseCount = 0;
    wrReg(3'd0, (32'd1 << 15) | (32'(dirWr) << 13) | (32'(quad) << 12) |
                (32'(dev) << 6) | 32'(div));
  endtask

  task automatic waitDone(int target, string req);
    int n = 0;
    while (doneCount < target && n < 20000) begin
      @(posedge clk);
      n++;
    end
    repeat (3) @(posedge clk);
    check(doneCount == target, req, "finished pulse count", 32'(doneCount), 32'(target));
  endtask

  initial begin
    logic [31:0] rd;
    logic [7:0]  none[$];
    logic [7:0]  bytesA[$];
    int          dones = 0;

    repeat (5) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    rdReg(3'd0, rd); check(rd == 0, "R1", "control after reset", rd, 0);
    rdReg(3'd1, rd); check(rd == 0, "R1", "select after reset", rd, 0);
    rdReg(3'd2, rd); check(rd == 0, "R1", "length after reset", rd, 0);
    rdReg(3'd4, rd); check(rd == 0, "R1", "status after reset", rd, 0);
    check(spiCsN == 3'b111, "R1", "chip selects after reset", 32'(spiCsN), 32'h7);
    check(!spiClk && !xferDone, "R1", "clock and pulse after reset", 32'({spiClk, xferDone}), 0);

    // R9: fill, overflow, drain, underflow
    rdReg(3'd3, rd); check(rd == 0, "R9", "read of empty FIFO", rd, 0);
    for (int i = 0; i < 8; i++) wrReg(3'd3, 32'h1000 + 32'(i));
    rdReg(3'd4, rd); check(rd == 1, "R9", "status full", rd, 1);
    wrReg(3'd3, 32'hDEAD);
    for (int i = 0; i < 8; i++) begin
      rdReg(3'd3, rd); check(rd == 32'h1000 + 32'(i), "R9", "FIFO order", rd, 32'h1000 + 32'(i));
    end
    rdReg(3'd3, rd); check(rd == 0, "R9", "overflow word dropped", rd, 0);
    rdReg(3'd4, rd); check(rd == 0, "R9", "status not full", rd, 0);

    // R4 R6 R3: single-line write, divisor 1, device 1, six bytes
    wrReg(3'd3, 32'h44332211);
    wrReg(3'd3, 32'hAABB6655);
    startXfer(1, 1, 0, 1, 6, none);
    rdReg(3'd0, rd); check(rd == 32'h0000A041, "R2", "control readback while busy", rd, 32'hA041);
    dones++; waitDone(dones, "R11");
    check(mosiSeen.size() == 6, "R4", "bytes sent", 32'(mosiSeen.size()), 6);
    for (int i = 0; i < 6 && i < mosiSeen.size(); i++)
      check(mosiSeen[i] == 8'(8'h11 * (i + 1)), "R6", "write byte order", 32'(mosiSeen[i]), 32'(8'h11 * (i + 1)));
    check(int'((riseT2 - riseT1) / CLK_PERIOD) == 4, "R3", "period divisor 1",
          32'(int'((riseT2 - riseT1) / CLK_PERIOD)), 4);
    rdReg(3'd3, rd); check(rd == 0, "R6", "tail of last write word discarded", rd, 0);
    rdReg(3'd0, rd); check(rd[15] == 1'b0, "R11", "busy cleared", 32'(rd[15]), 0);
    rdReg(3'd1, rd); check(rd == 1, "R7", "still selected after finish", rd, 1);
    check(spiCsN == 3'b101, "R7", "device 1 held", 32'(spiCsN), 32'h5);
    wrReg(3'd1, 0);
    rdReg(3'd1, rd); check(rd == 0, "R7", "deselected by software", rd, 0);

    // R5 R3: quad write, divisor 0, device 2, three bytes
    wrReg(3'd3, 32'h77C3B2A1);
    startXfer(0, 2, 1, 1, 3, none);
    @(negedge clk);
    check(spiDataOe == 4'hF, "R5", "quad write drives all lines", 32'(spiDataOe), 32'hF);
    dones++; waitDone(dones, "R11");
    check(mosiSeen.size() == 3, "R5", "quad bytes sent", 32'(mosiSeen.size()), 3);
    if (mosiSeen.size() == 3) begin
      check(mosiSeen[0] == 8'hA1, "R5", "quad byte 0", 32'(mosiSeen[0]), 32'hA1);
      check(mosiSeen[1] == 8'hB2, "R5", "quad byte 1", 32'(mosiSeen[1]), 32'hB2);
      check(mosiSeen[2] == 8'hC3, "R5", "quad byte 2", 32'(mosiSeen[2]), 32'hC3);
    end
    check(int'((riseT2 - riseT1) / CLK_PERIOD) == 2, "R3", "period divisor 0",
          32'(int'((riseT2 - riseT1) / CLK_PERIOD)), 2);
    wrReg(3'd1, 0);

    // R4 R6 R7 R2: single-line read, divisor 2, device 0, five bytes
    bytesA = '{8'h81, 8'h42, 8'h24, 8'h18, 8'hE7};
    startXfer(2, 0, 0, 0, 5, bytesA);
    wrReg(3'd1, 0);
    rdReg(3'd1, rd); check(rd == 1, "R7", "deselect while busy ignored", rd, 1);
    wrReg(3'd2, 99);
    rdReg(3'd2, rd); check(rd == 5, "R2", "length write while busy ignored", rd, 5);
    dones++; waitDone(dones, "R11");
    rdReg(3'd3, rd); check(rd == 32'h18244281, "R6", "read word LSB first", rd, 32'h18244281);
    rdReg(3'd3, rd); check(rd == 32'h000000E7, "R6", "partial word zero padded", rd, 32'hE7);
    check(int'((riseT2 - riseT1) / CLK_PERIOD) == 8, "R3", "period divisor 2",
          32'(int'((riseT2 - riseT1) / CLK_PERIOD)), 8);
    wrReg(3'd1, 0);

    // R5: quad read, divisor 1, device 1, four bytes
    bytesA = '{8'h5A, 8'hC3, 8'h0F, 8'hF0};
    startXfer(1, 1, 1, 0, 4, bytesA);
    @(negedge clk);
    check(spiDataOe == 4'h0, "R5", "quad read releases lines", 32'(spiDataOe), 0);
    dones++; waitDone(dones, "R11");
    rdReg(3'd3, rd); check(rd == 32'hF00FC35A, "R5", "quad read word", rd, 32'hF00FC35A);
    wrReg(3'd1, 0);

    // R8: upper length bits ignored, zero length completes without clocks
    wrReg(3'd2, 32'hFFE00000);
    rdReg(3'd2, rd); check(rd == 0, "R8", "length is 21 bits", rd, 0);
    startXfer(0, 0, 0, 1, 0, none);
    dones++; waitDone(dones, "R8");
    check(riseCount == 0, "R8", "no serial clock for zero length", 32'(riseCount), 0);
    wrReg(3'd1, 0);

    // R10: read of 36 bytes stalls at 32 with the FIFO full
    bytesA.delete();
    for (int i = 0; i < 36; i++) bytesA.push_back(8'(i));
    startXfer(0, 0, 0, 0, 36, bytesA);
    repeat (1200) @(posedge clk);
    rdReg(3'd4, rd); check(rd == 1, "R10", "FIFO full during stall", rd, 1);
    rdReg(3'd0, rd); check(rd[15] == 1'b1, "R10", "still busy during stall", 32'(rd[15]), 1);
    check(riseCount == 256, "R10", "clock stopped after 32 bytes", 32'(riseCount), 256);
    check(!spiClk, "R10", "clock parked low", 32'(spiClk), 0);
    for (int k = 0; k < 8; k++) begin
      logic [31:0] expW;
      expW = {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)};
      rdReg(3'd3, rd); check(rd == expW, "R10", "stalled read word", rd, expW);
    end
    dones++; waitDone(dones, "R11");
    rdReg(3'd3, rd); check(rd == 32'h23222120, "R10", "word after resume", rd, 32'h23222120);
    check(riseCount == 288, "R10", "total clock edges", 32'(riseCount), 288);
    wrReg(3'd1, 0);
    repeat (5) @(posedge clk);

    finishRun();
  end

endmodule